// File: doc/BRIEF.md
# Debug TAP with Scan-Chain Selection and Instruction Issue

This block is the target side of a JTAG debug port. A standard sixteen-state TAP controller steps on TCK and TMS. It drives a 5-bit instruction register and a set of data registers, and TDI-to-TDO routing depends on the loaded instruction and on a 5-bit chain number. The chain number is written through a dedicated select instruction.

One of the data registers is a 33-bit instruction-transfer chain. Through it a debugger loads a 32-bit opcode for the core and reads back a completion flag. Loading the right chain and an execute-capable instruction arms the port. Each later entry into Run-Test/Idle then hands exactly one opcode to the core as a single-cycle strobe. A shortcut instruction code reaches the transfer chain without rewriting the chain number.

The core side is modelled as a strobe with an opcode alongside it, plus a completion input that is sampled into the chain.

Top module: `dbgtap_top`

## Requirements
- R1: With `rst_n` low at a rising TCK edge, or in Test-Logic-Reset, the instruction becomes the bypass code 0x1F, the chain number becomes 0, the held opcode becomes 0, and `core_exec` and `tdo_en` stay low.
- R2: The instruction register is 5 bits wide. Capture-IR loads 5'b00001, Shift-IR shifts LSB first from TDI, and the new code takes effect only on Update-IR.
- R3: With code 0x02 (chain select) loaded, the data register is the 5-bit chain-select register. It captures 0x10 in Capture-DR, and a shifted value becomes the chain number only on Update-DR.
- R4: The transfer chain is 33 bits. The first 32 bits shifted, LSB first, form the opcode. The 33rd bit shifted out is `core_done` as sampled in Capture-DR. Capture also loads the held opcode into the low 32 bits, and Update-DR drives the new opcode onto `core_opcode`.
- R5: Code 0x1D routes the transfer chain for any chain number, including 5, and leaves the chain number unchanged.
- R6: The port is armed when the chain number is 4 or 5 and the instruction is 0x0C, 0x00 or 0x1D. When armed, each entry into Run-Test/Idle raises `core_exec` for exactly the first TCK cycle spent there. Further cycles in Run-Test/Idle add no strobes. Code 0x0C or 0x00 together with chain 4 also routes the transfer chain.
- R7: With chain number 0 (or any number other than 4 and 5), entering Run-Test/Idle never raises `core_exec`.
- R8: Any other combination of instruction and chain number routes a 1-bit bypass register that captures 0. TDO then repeats TDI one shift later.
- R9: TDO and `tdo_en` change only on falling TCK edges. `tdo_en` is high only in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable, high in shift states |
| core_opcode | output | OPW | Opcode held for the core |
| core_exec | output | 1 | One-cycle execute strobe to the core |
| core_done | input | 1 | Completion flag from the core |

## Verification
Two events can fall in the same TCK cycle. In the first, Update-IR or Update-DR writes a new instruction, chain number or opcode while the controller moves into Run-Test/Idle. In the second, the strobe decision reads those registers. The bench provokes the first case by loading an execute-capable instruction and going straight to Run-Test/Idle. It provokes the second by writing a new opcode and going straight to Run-Test/Idle. The scoreboard expects the strobe to carry the freshly written value. Other sequences end in Run-Test/Idle with a disarming instruction or chain number freshly written, and there the scoreboard expects no strobe at all.

// File: rtl/dbgtap_pkg.sv
// Shared types and instruction codes of the debug TAP.
// Assumes a fixed 5-bit instruction register; chain widths are module parameters.
package dbgtap_pkg;

    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] OP_EXTEST  = 5'h00;
    localparam logic [IR_W-1:0] OP_CHSEL   = 5'h02;
    localparam logic [IR_W-1:0] OP_INTEST  = 5'h0C;
    localparam logic [IR_W-1:0] OP_ITRSEL  = 5'h1D;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    typedef enum logic [1:0] {RT_BYPASS, RT_CHSEL, RT_ITR} route_e;

endpackage

// File: rtl/dbgtap_fsm.sv
// TAP state controller: sixteen states advanced by TMS on rising TCK.
// Assumes rst_n is synchronous to TCK; also exposes the next state.
module dbgtap_fsm
    import dbgtap_pkg::*;
(
    input  logic    tck,
    input  logic    rst_n,
    input  logic    tms,
    output tap_st_e state_q,
    output tap_st_e state_nx
);

    // Next-state table of the TAP controller.
    always_comb begin
        unique case (state_q)
            ST_RESET:  state_nx = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_nx = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  state_nx = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_nx = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  state_nx = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_nx = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_nx;
    end

endmodule

// File: rtl/dbgtap_ir.sv
// Instruction register: capture, LSB-first shift and update of the 5-bit code.
// Assumes the state input comes from dbgtap_fsm in the same TCK domain.
module dbgtap_ir
    import dbgtap_pkg::*;
#(
    parameter logic [IR_W-1:0] IR_CAPTURE = 5'b00001
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_st_e         state_q,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sh;

    // Shift stage and held instruction, both cleared by reset or Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || state_q == ST_RESET) begin
            ir_sh <= IR_CAPTURE;
            ir_q  <= OP_BYPASS;
        end else begin
            unique case (state_q)
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sh;
                default:   ;
            endcase
        end
    end

    assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/dbgtap_dr.sv
// Data registers: chain-select, instruction-transfer chain and bypass,
// routed by the held instruction and chain number.
// Assumes ir_q and chain_q only change in update or reset states.
module dbgtap_dr
    import dbgtap_pkg::*;
#(
    parameter int CSW         = 5,
    parameter int OPW         = 32,
    parameter int SEL_CAPTURE = 16,
    parameter int ITR_CHAIN   = 4
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_st_e         state_q,
    input  logic [IR_W-1:0] ir_q,
    input  logic            core_done,
    output logic [CSW-1:0]  chain_q,
    output logic [OPW-1:0]  opcode_q,
    output logic            dr_lsb
);

    localparam int ITRW = OPW + 1;

    route_e          route;
    logic [CSW-1:0]  sel_sh;
    logic [ITRW-1:0] itr_sh;
    logic            byp_sh;

    // Route decode from instruction and chain number.
    always_comb begin
        unique case (ir_q)
            OP_CHSEL:             route = RT_CHSEL;
            OP_ITRSEL:            route = RT_ITR;
            OP_INTEST, OP_EXTEST: route = (chain_q == CSW'(ITR_CHAIN)) ? RT_ITR : RT_BYPASS;
            default:              route = RT_BYPASS;
        endcase
    end

    // Capture, shift and update of the routed register only.
    always_ff @(posedge tck) begin
        if (!rst_n || state_q == ST_RESET) begin
            sel_sh   <= '0;
            itr_sh   <= '0;
            byp_sh   <= 1'b0;
            chain_q  <= '0;
            opcode_q <= '0;
        end else begin
            unique case (state_q)
                ST_CAP_DR: begin
                    unique case (route)
                        RT_CHSEL: sel_sh <= CSW'(SEL_CAPTURE);
                        RT_ITR:   itr_sh <= {core_done, opcode_q};
                        default:  byp_sh <= 1'b0;
                    endcase
                end
                ST_SH_DR: begin
                    unique case (route)
                        RT_CHSEL: sel_sh <= {tdi, sel_sh[CSW-1:1]};
                        RT_ITR:   itr_sh <= {tdi, itr_sh[ITRW-1:1]};
                        default:  byp_sh <= tdi;
                    endcase
                end
                ST_UPD_DR: begin
                    unique case (route)
                        RT_CHSEL: chain_q  <= sel_sh;
                        RT_ITR:   opcode_q <= itr_sh[OPW-1:0];
                        default:  ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Serial output bit of the routed register.
    always_comb begin
        unique case (route)
            RT_CHSEL: dr_lsb = sel_sh[0];
            RT_ITR:   dr_lsb = itr_sh[0];
            default:  dr_lsb = byp_sh;
        endcase
    end

endmodule

// File: rtl/dbgtap_issue.sv
// Execute-strobe generator: one pulse on each entry into Run-Test/Idle
// while an execute chain and an execute-capable instruction are held.
// Assumes the strobe is sampled by the core on rising TCK.
module dbgtap_issue
    import dbgtap_pkg::*;
#(
    parameter int CSW        = 5,
    parameter int ITR_CHAIN  = 4,
    parameter int DATA_CHAIN = 5
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_st_e         state_q,
    input  tap_st_e         state_nx,
    input  logic [IR_W-1:0] ir_q,
    input  logic [CSW-1:0]  chain_q,
    output logic            core_exec
);

    logic first_idle_q;
    logic armed;

    // Marks the first cycle after a transition into Run-Test/Idle.
    always_ff @(posedge tck) begin
        if (!rst_n) first_idle_q <= 1'b0;
        else        first_idle_q <= (state_nx == ST_IDLE) && (state_q != ST_IDLE);
    end

    // Arming condition, evaluated on the values written by the preceding update.
    always_comb begin
        armed = ((chain_q == CSW'(ITR_CHAIN)) || (chain_q == CSW'(DATA_CHAIN))) &&
                ((ir_q == OP_INTEST) || (ir_q == OP_EXTEST) || (ir_q == OP_ITRSEL));
    end

    assign core_exec = first_idle_q && (state_q == ST_IDLE) && armed;

endmodule

// File: rtl/dbgtap_top.sv
// Debug TAP top: controller, instruction register, data registers and issue logic.
// Assumes a single TCK domain; TDO is retimed to the falling edge.
module dbgtap_top
    import dbgtap_pkg::*;
#(
    parameter int CSW         = 5,
    parameter int OPW         = 32,
    parameter int SEL_CAPTURE = 16,
    parameter int ITR_CHAIN   = 4,
    parameter int DATA_CHAIN  = 5
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           tms,
    input  logic           tdi,
    output logic           tdo,
    output logic           tdo_en,
    output logic [OPW-1:0] core_opcode,
    output logic           core_exec,
    input  logic           core_done
);

    tap_st_e         tap_state;
    tap_st_e         tap_next;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic [CSW-1:0]  chain_q;
    logic            dr_lsb;
    logic            shifting;

    dbgtap_fsm fsm_i (
        .tck(tck), .rst_n(rst_n), .tms(tms),
        .state_q(tap_state), .state_nx(tap_next)
    );

    dbgtap_ir ir_i (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .state_q(tap_state),
        .ir_q(ir_q), .ir_lsb(ir_lsb)
    );

    dbgtap_dr #(
        .CSW(CSW), .OPW(OPW), .SEL_CAPTURE(SEL_CAPTURE), .ITR_CHAIN(ITR_CHAIN)
    ) dr_i (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .state_q(tap_state), .ir_q(ir_q),
        .core_done(core_done), .chain_q(chain_q), .opcode_q(core_opcode), .dr_lsb(dr_lsb)
    );

    dbgtap_issue #(
        .CSW(CSW), .ITR_CHAIN(ITR_CHAIN), .DATA_CHAIN(DATA_CHAIN)
    ) issue_i (
        .tck(tck), .rst_n(rst_n), .state_q(tap_state), .state_nx(tap_next),
        .ir_q(ir_q), .chain_q(chain_q), .core_exec(core_exec)
    );

    assign shifting = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);

    // Falling-edge retiming of the serial output and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shifting;
            tdo    <= !shifting ? 1'b0 : ((tap_state == ST_SH_IR) ? ir_lsb : dr_lsb);
        end
    end

endmodule

// File: rtl/dbgtap_chk.sv
// Protocol checker for dbgtap_top, attached by bind below.
// Assumes rst_n is held low over the first rising TCK edge.
module dbgtap_chk
    import dbgtap_pkg::*;
#(
    parameter int CSW        = 5,
    parameter int ITR_CHAIN  = 4,
    parameter int DATA_CHAIN = 5
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tdo_en,
    input logic            core_exec,
    input tap_st_e         tap_state,
    input logic [IR_W-1:0] ir_q,
    input logic [CSW-1:0]  chain_q
);

    // R1: Test-Logic-Reset leaves the bypass code and chain 0
    a_r1_tlr_clears: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == ST_RESET) |=> (ir_q == OP_BYPASS && chain_q == '0));

    // R2: the instruction only moves on Update-IR or reset
    a_r2_ir_holds: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state != ST_UPD_IR && tap_state != ST_RESET) |=> $stable(ir_q));

    // R3: the chain number only moves on Update-DR or reset
    a_r3_chain_holds: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state != ST_UPD_DR && tap_state != ST_RESET) |=> $stable(chain_q));

    // R6: the strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge tck) disable iff (!rst_n)
        core_exec |=> !core_exec);

    // R6: the strobe occurs only in Run-Test/Idle
    a_r6_exec_in_idle: assert property (@(posedge tck) disable iff (!rst_n)
        core_exec |-> (tap_state == ST_IDLE));

    // R7: no strobe unless an execute chain is selected
    a_r7_exec_chain: assert property (@(posedge tck) disable iff (!rst_n)
        core_exec |-> (chain_q == CSW'(ITR_CHAIN) || chain_q == CSW'(DATA_CHAIN)));

    // R9: the output is enabled only in shift states
    a_r9_tdo_en_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (tap_state == ST_SH_IR || tap_state == ST_SH_DR));

endmodule

bind dbgtap_top dbgtap_chk #(
    .CSW(CSW), .ITR_CHAIN(ITR_CHAIN), .DATA_CHAIN(DATA_CHAIN)
) chk_i (
    .tck(tck), .rst_n(rst_n), .tdo_en(tdo_en), .core_exec(core_exec),
    .tap_state(tap_state), .ir_q(ir_q), .chain_q(chain_q)
);

// File: tb/dbgtap_top_tb_top.sv
// Scoreboard bench: scan tasks push expected strobe opcodes, a monitor pops them.
module dbgtap_top_tb_top;

    localparam logic [4:0] C_EXTEST = 5'h00;
    localparam logic [4:0] C_CHSEL  = 5'h02;
    localparam logic [4:0] C_INTEST = 5'h0C;
    localparam logic [4:0] C_ITRSEL = 5'h1D;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        core_done = 1'b0;
    logic        tdo;
    logic        tdo_en;
    logic        core_exec;
    logic [31:0] core_opcode;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          at_idle = 1'b0;
    logic [31:0] exp_q[$];

    always #5 tck = ~tck;

    dbgtap_top dut_i (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .core_opcode(core_opcode), .core_exec(core_exec), .core_done(core_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
        o = tdo;
    endtask

    task automatic nav(input logic m);
        logic o;
        step(m, 1'b0, o);
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [63:0] val,
                        input bit go_idle, output logic [63:0] got, output logic en_ok);
        logic o;
        if (at_idle) nav(1'b1);
        if (is_ir) nav(1'b1);
        nav(1'b0);
        nav(1'b0);
        got = '0;
        en_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, val[i], o);
            got[i] = o;
            if (tdo_en !== 1'b1) en_ok = 1'b0;
        end
        nav(1'b1);
        nav(go_idle ? 1'b0 : 1'b1);
        at_idle = go_idle;
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) nav(1'b0);
    endtask

    // Monitor: every strobe must match the next expected opcode.
    always @(posedge tck) begin
        #2;
        if (rst_n && core_exec === 1'b1) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6/R7 unexpected strobe actual=%0h expected=none", core_opcode);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (core_opcode !== e) begin
                    n_bad++;
                    $display("FAIL R6 strobe opcode actual=%0h expected=%0h", core_opcode, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge tck);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] got;
        logic        en;

        repeat (3) @(posedge tck);
        #1;
        check("R1 reset tdo_en", tdo_en, 0);
        check("R1 reset core_exec", core_exec, 0);
        check("R1 reset opcode", core_opcode, 0);
        @(negedge tck);
        rst_n = 1'b1;
        nav(1'b0);
        at_idle = 1'b1;

        // R2 capture value, R3 chain-select capture
        scan(1, 5, C_CHSEL, 0, got, en);
        check("R2 IR capture", got[4:0], 5'h01);
        check("R9 tdo_en in Shift-IR", en, 1);
        scan(0, 5, 64'd4, 1, got, en);
        check("R3 select capture", got[4:0], 5'h10);
        check("R9 tdo_en low in idle", tdo_en, 0);
        idle_wait(2);
        check("R7 no strobe for select code", exp_q.size(), 0);

        // R4, R6: INTEST with chain 4, opcode load then Idle
        core_done = 1'b1;
        scan(1, 5, C_INTEST, 0, got, en);
        check("R2 IR capture again", got[4:0], 5'h01);
        exp_q.push_back(32'hE1A00000);
        scan(0, 33, {32'h0, 32'hE1A00000}, 1, got, en);
        check("R4 readback opcode", got[31:0], 32'h0);
        check("R4 done flag high", got[32], 1);
        check("R9 tdo_en in Shift-DR", en, 1);
        idle_wait(3);
        check("R6 one strobe only", exp_q.size(), 0);

        core_done = 1'b0;
        exp_q.push_back(32'h12345678);
        scan(0, 33, {32'h0, 32'h12345678}, 1, got, en);
        check("R4 readback previous opcode", got[31:0], 32'hE1A00000);
        check("R4 done flag low", got[32], 0);
        idle_wait(2);

        // R6: strobe after Update-IR into Idle
        exp_q.push_back(32'h12345678);
        scan(1, 5, C_EXTEST, 1, got, en);
        idle_wait(3);
        check("R6 strobe after IR update", exp_q.size(), 0);

        // R5: shortcut code with chain 5
        scan(1, 5, C_CHSEL, 0, got, en);
        scan(0, 5, 64'd5, 0, got, en);
        scan(1, 5, C_ITRSEL, 0, got, en);
        core_done = 1'b1;
        exp_q.push_back(32'hCAFEF00D);
        scan(0, 33, {32'h0, 32'hCAFEF00D}, 1, got, en);
        check("R5 shortcut routes chain, flag", got[32], 1);
        check("R5 shortcut routes chain, data", got[31:0], 32'h12345678);
        idle_wait(2);
        check("R5 shortcut strobe", exp_q.size(), 0);

        // R8 bypass with chain 5 + EXTEST; strobe proves chain kept (R5)
        scan(1, 5, C_EXTEST, 0, got, en);
        exp_q.push_back(32'hCAFEF00D);
        scan(0, 3, 64'b011, 1, got, en);
        check("R8 bypass chain 5, R9 tdo held to falling edge", got[2:0], 3'b110);
        idle_wait(2);
        check("R5 chain number unchanged", exp_q.size(), 0);

        // R7: chain 0 disables issue
        scan(1, 5, C_CHSEL, 0, got, en);
        scan(0, 5, 64'd0, 0, got, en);
        scan(1, 5, C_INTEST, 1, got, en);
        scan(0, 4, 64'b0101, 1, got, en);
        check("R8 bypass chain 0", got[3:0], 4'b1010);
        idle_wait(3);
        check("R7 no strobe with chain 0", exp_q.size(), 0);

        // R8: unknown instruction
        scan(1, 5, 64'h15, 0, got, en);
        check("R2 IR capture on unknown", got[4:0], 5'h01);
        scan(0, 3, 64'b001, 1, got, en);
        check("R8 bypass unknown code", got[2:0], 3'b010);

        // R1: Test-Logic-Reset via TMS
        scan(1, 5, C_CHSEL, 0, got, en);
        scan(0, 5, 64'd4, 0, got, en);
        exp_q.push_back(32'hCAFEF00D);
        scan(1, 5, C_INTEST, 1, got, en);
        idle_wait(1);
        for (int i = 0; i < 5; i++) nav(1'b1);
        nav(1'b0);
        at_idle = 1'b1;
        check("R1 TLR clears opcode", core_opcode, 0);
        check("R1 TLR tdo_en low", tdo_en, 0);
        scan(0, 2, 64'b11, 1, got, en);
        check("R1 TLR leaves bypass code", got[1:0], 2'b10);
        scan(1, 5, C_INTEST, 1, got, en);
        idle_wait(3);
        check("R1 TLR clears chain (no strobe)", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule